// File: doc/BRIEF.md
# SPI Transfer Request Validator

This block checks one SPI transfer request against the fixed capability values of a controller before any bus activity starts. A request gives the peripheral select index, the word size, the data lane widths for the two directions, the clock and framing mode bits, the bit rate, four optional timing delays, a flag asking for the select line to be released between transfers, the transfer kind, and the lengths of the transmit and receive buffers. The capability inputs say what the controller can do. Some limits use zero to mean "no limit". Others use zero to mean "not supported".

A pulse on `start` samples the request and the capabilities. One cycle later `done` pulses and two results appear: a status bit (0 = request valid, 1 = parameter error) and a bitmap with one bit per failed check, for debug. Both results hold their values until the next `start`. The block only validates requests. Running the transfer belongs to a separate engine.

Top module: `spi_req_checker`

## Requirements
- R1: Error bit 0 is set when the requested select index is greater than or equal to `cap_cs_count`.
- R2: Error bit 1 (word size) is set under these rules. When `cap_bpw_mask` is zero, any word size is accepted, including 0. Otherwise a word size n is accepted only when 1 <= n <= 32 and mask bit n-1 is 1.
- R3: Lane fields are decoded as follows: 0 or 1 is single, 2 is dual, 4 is quad and 8 is octal. Any other value is an error. In a 3-bit lane capability, bit 0 allows dual, bit 1 allows quad and bit 2 allows octal. Single is always allowed. A transmit lane failure sets error bit 2. A receive lane failure sets error bit 3.
- R4: `req_mode` bit 0 is clock phase and bit 1 is clock polarity. `cap_mode[1:0]` controls phase and `cap_mode[3:2]` controls polarity, with this encoding: 00 allows both values, 01 allows only 0, 10 allows only 1, and 11 allows neither. A phase violation sets error bit 4. A polarity violation sets error bit 5.
- R5: `req_mode` bit 2 requests an active-high select, bit 3 requests LSB-first order and bit 4 requests loopback. Each request is allowed only when `cap_mode` bit 4, 5 or 6 respectively is 1. Violations set error bits 6, 7 and 8. When these request bits are cleared, no error results regardless of the capability.
- R6: When `cap_freq_max` is zero, any rate is accepted. Otherwise a requested rate above `cap_freq_max` sets error bit 9.
- R7: The word, setup, hold and inactive delays set error bits 10, 11, 12 and 13 under these rules. When the delay's maximum is zero, any nonzero request is an error. When the maximum is nonzero, a request above it is an error.
- R8: Error bit 14 is set when `req_cs_toggle` is 1 and `cap_cs_toggle` is 0.
- R9: `xfer_kind` encodes the transfer kind: 0 is half-duplex read, 1 is half-duplex write, 2 is full duplex. For kind 2, `tx_len` not equal to `rx_len` sets error bit 15. Lengths are not compared for kinds 0 and 1.
- R10: `xfer_kind` value 3 is reserved and sets error bit 16.
- R11: `done` pulses for exactly one cycle, one clock after `start`. `err_map` and `status` then reflect the inputs present at that `start`. `status` equals the OR of `err_map`. Both hold until the next `start`, whatever the inputs do in between.
- R12: While reset is asserted and after it, until the first `start`, `done`, `status` and `err_map` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample request and capabilities |
| xfer_kind | input | 2 | 0 read, 1 write, 2 full duplex, 3 reserved |
| req_cs | input | CS_W | Requested select index |
| req_bpw | input | BPW_W | Requested bits per word |
| req_cs_toggle | input | 1 | Release select between transfers |
| req_tx_lanes | input | 8 | Transmit lane width code |
| req_rx_lanes | input | 8 | Receive lane width code |
| req_mode | input | 5 | Phase, polarity, active-high select, LSB first, loopback |
| req_freq | input | RATE_W | Requested bit rate |
| req_word_dly | input | DLY_W | Delay between words |
| req_setup_dly | input | DLY_W | Delay after select asserts |
| req_hold_dly | input | DLY_W | Delay before select releases |
| req_idle_dly | input | DLY_W | Delay while select is released |
| tx_len | input | LEN_W | Transmit buffer length |
| rx_len | input | LEN_W | Receive buffer length |
| cap_cs_count | input | CS_W | Number of select lines |
| cap_cs_toggle | input | 1 | Select release between transfers supported |
| cap_tx_lanes | input | 3 | Transmit lane capability |
| cap_rx_lanes | input | 3 | Receive lane capability |
| cap_bpw_mask | input | BPW_MAX | Supported word sizes |
| cap_mode | input | 7 | Phase, polarity and optional-feature capability |
| cap_freq_max | input | RATE_W | Maximum rate, 0 = unlimited |
| cap_word_dly_max | input | DLY_W | Maximum word delay, 0 = unsupported |
| cap_setup_max | input | DLY_W | Maximum setup delay, 0 = unsupported |
| cap_hold_max | input | DLY_W | Maximum hold delay, 0 = unsupported |
| cap_idle_max | input | DLY_W | Maximum inactive delay, 0 = unsupported |
| done | output | 1 | Result-valid pulse |
| status | output | 1 | 0 valid, 1 parameter error |
| err_map | output | 17 | One bit per failed check |

## Verification
The only state in this block is the result register, so any internal fault shows up at the ports one clock after `start`. If a check is mis-decoded, the matching `err_map` bit is wrong in that cycle, and `status` is wrong with it. If the hold logic is broken, the results change while `start` is low, so the bench reads them again after changing the inputs. Each zero-limit rule has its own vector because the two zero meanings are easy to swap.

// File: rtl/spi_req_chk_pkg.sv
package spi_req_chk_pkg;

    localparam int NUM_CHECKS = 17;

    localparam int E_CS      = 0;
    localparam int E_BPW     = 1;
    localparam int E_TXLN    = 2;
    localparam int E_RXLN    = 3;
    localparam int E_PHASE   = 4;
    localparam int E_POL     = 5;
    localparam int E_CSHIGH  = 6;
    localparam int E_LSB     = 7;
    localparam int E_LOOP    = 8;
    localparam int E_FREQ    = 9;
    localparam int E_DLY0    = 10;
    localparam int E_TOGGLE  = 14;
    localparam int E_LEN     = 15;
    localparam int E_KIND    = 16;

    typedef enum logic [1:0] {
        XK_READ   = 2'd0,
        XK_WRITE  = 2'd1,
        XK_DUPLEX = 2'd2,
        XK_RSVD   = 2'd3
    } xfer_kind_e;

    typedef enum logic [1:0] {
        LW_SINGLE = 2'd0,
        LW_DUAL   = 2'd1,
        LW_QUAD   = 2'd2,
        LW_OCTAL  = 2'd3
    } lane_width_e;

    typedef struct packed {
        logic        legal;
        lane_width_e width;
    } lane_dec_t;

    typedef struct packed {
        logic loopback;
        logic lsb_first;
        logic cs_high;
        logic polarity;
        logic phase;
    } mode_req_t;

    typedef struct packed {
        logic       loopback_ok;
        logic       lsb_first_ok;
        logic       cs_high_ok;
        logic [1:0] polarity_sel;
        logic [1:0] phase_sel;
    } mode_cap_t;

    function automatic lane_dec_t decode_lanes(input logic [7:0] code);
        lane_dec_t d;
        d.legal = 1'b1;
        d.width = LW_SINGLE;
        case (code)
            8'd0, 8'd1: d.width = LW_SINGLE;
            8'd2:       d.width = LW_DUAL;
            8'd4:       d.width = LW_QUAD;
            8'd8:       d.width = LW_OCTAL;
            default:    d.legal = 1'b0;
        endcase
        return d;
    endfunction

    function automatic logic choice_allowed(input logic [1:0] sel, input logic setting);
        case (sel)
            2'b00:   return 1'b1;
            2'b01:   return !setting;
            2'b10:   return setting;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/spi_chk_lane.sv
module spi_chk_lane
    import spi_req_chk_pkg::*;
(
    input  logic [7:0] req_lanes,
    input  logic [2:0] cap_lanes,
    output logic       err
);
    lane_dec_t dec;
    logic      allowed;

    always_comb begin
        dec = decode_lanes(req_lanes);
        case (dec.width)
            LW_SINGLE: allowed = 1'b1;
            LW_DUAL:   allowed = cap_lanes[0];
            LW_QUAD:   allowed = cap_lanes[1];
            default:   allowed = cap_lanes[2];
        endcase
        err = !dec.legal || !allowed;
    end
endmodule

// File: rtl/spi_chk_mode.sv
module spi_chk_mode
    import spi_req_chk_pkg::*;
(
    input  logic [4:0] req_mode,
    input  logic [6:0] cap_mode,
    output logic [4:0] err
);
    mode_req_t m;
    mode_cap_t c;

    always_comb begin
        m = mode_req_t'(req_mode);
        c = mode_cap_t'(cap_mode);
        err[0] = !choice_allowed(c.phase_sel, m.phase);
        err[1] = !choice_allowed(c.polarity_sel, m.polarity);
        err[2] = m.cs_high   && !c.cs_high_ok;
        err[3] = m.lsb_first && !c.lsb_first_ok;
        err[4] = m.loopback  && !c.loopback_ok;
    end
endmodule

// File: rtl/spi_chk_limit.sv
module spi_chk_limit #(
    parameter int W                 = 32,
    parameter bit ZERO_IS_UNLIMITED = 1'b1
) (
    input  logic [W-1:0] req,
    input  logic [W-1:0] max_val,
    output logic         err
);
    logic over;
    assign over = (req > max_val);

    generate
        if (ZERO_IS_UNLIMITED) begin : g_unlim
            assign err = (max_val != '0) && over;
        end else begin : g_unsup
            assign err = over;
        end
    endgenerate
endmodule

// File: rtl/spi_req_checker.sv
module spi_req_checker
    import spi_req_chk_pkg::*;
#(
    parameter int CS_W    = 8,
    parameter int BPW_W   = 8,
    parameter int BPW_MAX = 32,
    parameter int LEN_W   = 16,
    parameter int RATE_W  = 32,
    parameter int DLY_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [1:0]            xfer_kind,
    input  logic [CS_W-1:0]       req_cs,
    input  logic [BPW_W-1:0]      req_bpw,
    input  logic                  req_cs_toggle,
    input  logic [7:0]            req_tx_lanes,
    input  logic [7:0]            req_rx_lanes,
    input  logic [4:0]            req_mode,
    input  logic [RATE_W-1:0]     req_freq,
    input  logic [DLY_W-1:0]      req_word_dly,
    input  logic [DLY_W-1:0]      req_setup_dly,
    input  logic [DLY_W-1:0]      req_hold_dly,
    input  logic [DLY_W-1:0]      req_idle_dly,
    input  logic [LEN_W-1:0]      tx_len,
    input  logic [LEN_W-1:0]      rx_len,
    input  logic [CS_W-1:0]       cap_cs_count,
    input  logic                  cap_cs_toggle,
    input  logic [2:0]            cap_tx_lanes,
    input  logic [2:0]            cap_rx_lanes,
    input  logic [BPW_MAX-1:0]    cap_bpw_mask,
    input  logic [6:0]            cap_mode,
    input  logic [RATE_W-1:0]     cap_freq_max,
    input  logic [DLY_W-1:0]      cap_word_dly_max,
    input  logic [DLY_W-1:0]      cap_setup_max,
    input  logic [DLY_W-1:0]      cap_hold_max,
    input  logic [DLY_W-1:0]      cap_idle_max,
    output logic                  done,
    output logic                  status,
    output logic [NUM_CHECKS-1:0] err_map
);
    localparam int NUM_DLY = 4;
    localparam int IDX_W   = (BPW_MAX > 1) ? $clog2(BPW_MAX) : 1;

    logic [NUM_CHECKS-1:0] err_next;
    logic                  tx_ln_err, rx_ln_err, freq_err, bpw_err;
    logic [4:0]            mode_err;
    logic [NUM_DLY-1:0]    dly_err;
    logic [DLY_W-1:0]      dly_req [NUM_DLY];
    logic [DLY_W-1:0]      dly_max [NUM_DLY];
    logic [BPW_W-1:0]      bpw_m1;
    xfer_kind_e            kind;

    spi_chk_lane u_tx_lane (.req_lanes(req_tx_lanes), .cap_lanes(cap_tx_lanes), .err(tx_ln_err));
    spi_chk_lane u_rx_lane (.req_lanes(req_rx_lanes), .cap_lanes(cap_rx_lanes), .err(rx_ln_err));
    spi_chk_mode u_mode    (.req_mode(req_mode), .cap_mode(cap_mode), .err(mode_err));

    spi_chk_limit #(.W(RATE_W), .ZERO_IS_UNLIMITED(1'b1)) u_freq (
        .req(req_freq), .max_val(cap_freq_max), .err(freq_err)
    );

    assign dly_req[0] = req_word_dly;
    assign dly_req[1] = req_setup_dly;
    assign dly_req[2] = req_hold_dly;
    assign dly_req[3] = req_idle_dly;
    assign dly_max[0] = cap_word_dly_max;
    assign dly_max[1] = cap_setup_max;
    assign dly_max[2] = cap_hold_max;
    assign dly_max[3] = cap_idle_max;

    generate
        for (genvar g = 0; g < NUM_DLY; g++) begin : g_dly
            spi_chk_limit #(.W(DLY_W), .ZERO_IS_UNLIMITED(1'b0)) u_dly (
                .req(dly_req[g]), .max_val(dly_max[g]), .err(dly_err[g])
            );
        end
    endgenerate

    // word size against the supported-size mask
    always_comb begin
        bpw_m1 = req_bpw - BPW_W'(1);
        if (cap_bpw_mask == '0)
            bpw_err = 1'b0;
        else if (req_bpw == '0 || req_bpw > BPW_W'(BPW_MAX))
            bpw_err = 1'b1;
        else
            bpw_err = !cap_bpw_mask[bpw_m1[IDX_W-1:0]];
    end

    always_comb begin
        kind                  = xfer_kind_e'(xfer_kind);
        err_next              = '0;
        err_next[E_CS]        = (req_cs >= cap_cs_count);
        err_next[E_BPW]       = bpw_err;
        err_next[E_TXLN]      = tx_ln_err;
        err_next[E_RXLN]      = rx_ln_err;
        err_next[E_PHASE]     = mode_err[0];
        err_next[E_POL]       = mode_err[1];
        err_next[E_CSHIGH]    = mode_err[2];
        err_next[E_LSB]       = mode_err[3];
        err_next[E_LOOP]      = mode_err[4];
        err_next[E_FREQ]      = freq_err;
        err_next[E_DLY0 +: NUM_DLY] = dly_err;
        err_next[E_TOGGLE]    = req_cs_toggle && !cap_cs_toggle;
        err_next[E_LEN]       = (kind == XK_DUPLEX) && (tx_len != rx_len);
        err_next[E_KIND]      = (kind == XK_RSVD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            status  <= 1'b0;
            err_map <= '0;
        end else begin
            done <= start;
            if (start) begin
                err_map <= err_next;
                status  <= |err_next;
            end
        end
    end

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> done);                                                    // R11
    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start));                                             // R11
    AST_STATUS_IS_ANY_ERR: assert property (@(posedge clk) disable iff (rst)
        status == (err_map != '0));                                         // R11
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(status) && $stable(err_map)));                  // R11
    AST_CS_RANGE: assert property (@(posedge clk) disable iff (rst)
        (start && (req_cs >= cap_cs_count)) |=> (err_map[E_CS] && status)); // R1
    AST_DUPLEX_LEN: assert property (@(posedge clk) disable iff (rst)
        (start && xfer_kind == 2'd2 && tx_len != rx_len) |=> status);       // R9
    AST_RSVD_KIND: assert property (@(posedge clk) disable iff (rst)
        (start && xfer_kind == 2'd3) |=> err_map[E_KIND]);                  // R10
endmodule

// File: tb/sim_spi_req_checker.sv
module sim_spi_req_checker;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, start, req_cs_toggle, cap_cs_toggle;
    logic [1:0]  xfer_kind;
    logic [7:0]  req_cs, req_bpw, req_tx_lanes, req_rx_lanes, cap_cs_count;
    logic [4:0]  req_mode;
    logic [31:0] req_freq, req_word_dly, req_setup_dly, req_hold_dly, req_idle_dly;
    logic [15:0] tx_len, rx_len;
    logic [2:0]  cap_tx_lanes, cap_rx_lanes;
    logic [31:0] cap_bpw_mask, cap_freq_max, cap_word_dly_max, cap_setup_max, cap_hold_max, cap_idle_max;
    logic [6:0]  cap_mode;
    logic        done, status;
    logic [16:0] err_map;

    int total = 0;
    int fails = 0;

    spi_req_checker u0 (
        .clk(clk), .rst(rst), .start(start), .xfer_kind(xfer_kind),
        .req_cs(req_cs), .req_bpw(req_bpw), .req_cs_toggle(req_cs_toggle),
        .req_tx_lanes(req_tx_lanes), .req_rx_lanes(req_rx_lanes), .req_mode(req_mode),
        .req_freq(req_freq), .req_word_dly(req_word_dly), .req_setup_dly(req_setup_dly),
        .req_hold_dly(req_hold_dly), .req_idle_dly(req_idle_dly),
        .tx_len(tx_len), .rx_len(rx_len),
        .cap_cs_count(cap_cs_count), .cap_cs_toggle(cap_cs_toggle),
        .cap_tx_lanes(cap_tx_lanes), .cap_rx_lanes(cap_rx_lanes),
        .cap_bpw_mask(cap_bpw_mask), .cap_mode(cap_mode), .cap_freq_max(cap_freq_max),
        .cap_word_dly_max(cap_word_dly_max), .cap_setup_max(cap_setup_max),
        .cap_hold_max(cap_hold_max), .cap_idle_max(cap_idle_max),
        .done(done), .status(status), .err_map(err_map)
    );

    // vector = {code[4:0], value[31:0], expected err_map[16:0]}
    localparam int NV = 38;
    localparam logic [53:0] VEC [NV] = '{
        {5'd0,  32'd0,          17'h00000},  // R11 baseline valid
        {5'd1,  32'd3,          17'h00000},  // R1 highest legal index
        {5'd1,  32'd4,          17'h00001},  // R1 index == count
        {5'd2,  32'd16,         17'h00000},  // R2
        {5'd2,  32'd9,          17'h00002},  // R2
        {5'd2,  32'd0,          17'h00002},  // R2
        {5'd2,  32'd40,         17'h00002},  // R2
        {5'd3,  32'd2,          17'h00000},  // R3 tx dual
        {5'd3,  32'd4,          17'h00000},  // R3 tx quad
        {5'd3,  32'd8,          17'h00004},  // R3 tx octal not allowed
        {5'd3,  32'd3,          17'h00004},  // R3 illegal code
        {5'd4,  32'd2,          17'h00000},  // R3 rx dual
        {5'd4,  32'd4,          17'h00008},  // R3 rx quad not allowed
        {5'd4,  32'd1,          17'h00000},  // R3 rx single
        {5'd5,  32'd1,          17'h00000},  // R4 phase 1 allowed
        {5'd5,  32'd2,          17'h00020},  // R4 polarity 1 rejected
        {5'd5,  32'd4,          17'h00000},  // R5 active-high allowed
        {5'd5,  32'd8,          17'h00080},  // R5 lsb-first
        {5'd5,  32'd16,         17'h00100},  // R5 loopback
        {5'd5,  32'h1A,         17'h001A0},  // R4 R5 several at once
        {5'd6,  32'd50000000,   17'h00000},  // R6 at limit
        {5'd6,  32'd50000001,   17'h00200},  // R6 above
        {5'd7,  32'd100,        17'h00000},  // R7 word at limit
        {5'd7,  32'd101,        17'h00400},  // R7 word above
        {5'd8,  32'd1,          17'h00800},  // R7 setup unsupported
        {5'd9,  32'd201,        17'h01000},  // R7 hold above
        {5'd10, 32'd301,        17'h02000},  // R7 inactive above
        {5'd11, 32'd1,          17'h00000},  // R8 toggle supported
        {5'd12, 32'd0,          17'h00000},  // R9 read, lengths ignored
        {5'd12, 32'd1,          17'h00000},  // R9 write, lengths ignored
        {5'd12, 32'd2,          17'h08000},  // R9 duplex mismatch
        {5'd12, 32'd3,          17'h10000},  // R10 reserved kind
        {5'd13, 32'd1,          17'h00010},  // R4 cap phase 0 only
        {5'd13, 32'd2,          17'h00000},  // R4 cap phase 1 only
        {5'd13, 32'd3,          17'h00010},  // R4 cap 11 allows none
        {5'd14, 32'd0,          17'h04000},  // R8 toggle unsupported
        {5'd15, 32'd40,         17'h00000},  // R2 empty mask
        {5'd16, 32'hFFFFFFFF,   17'h00000}   // R6 unlimited rate
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic baseline();
        xfer_kind = 2'd2; req_cs = 8'd1; req_bpw = 8'd8; req_cs_toggle = 1'b0;
        req_tx_lanes = 8'd1; req_rx_lanes = 8'd0; req_mode = 5'd0;
        req_freq = 32'd10000000; req_word_dly = 32'd0; req_setup_dly = 32'd0;
        req_hold_dly = 32'd50; req_idle_dly = 32'd300; tx_len = 16'd16; rx_len = 16'd16;
        cap_cs_count = 8'd4; cap_cs_toggle = 1'b1; cap_tx_lanes = 3'b011; cap_rx_lanes = 3'b001;
        cap_bpw_mask = 32'h0000_8080; cap_mode = 7'h14; cap_freq_max = 32'd50000000;
        cap_word_dly_max = 32'd100; cap_setup_max = 32'd0; cap_hold_max = 32'd200;
        cap_idle_max = 32'd300;
    endtask

    task automatic apply(input logic [4:0] code, input logic [31:0] v);
        baseline();
        case (code)
            5'd1:  req_cs = v[7:0];
            5'd2:  req_bpw = v[7:0];
            5'd3:  req_tx_lanes = v[7:0];
            5'd4:  req_rx_lanes = v[7:0];
            5'd5:  req_mode = v[4:0];
            5'd6:  req_freq = v;
            5'd7:  req_word_dly = v;
            5'd8:  req_setup_dly = v;
            5'd9:  req_hold_dly = v;
            5'd10: req_idle_dly = v;
            5'd11: req_cs_toggle = v[0];
            5'd12: begin xfer_kind = v[1:0]; rx_len = 16'd8; end
            5'd13: begin cap_mode[1:0] = v[1:0]; req_mode = 5'd1; end
            5'd14: begin cap_cs_toggle = 1'b0; req_cs_toggle = 1'b1; end
            5'd15: begin cap_bpw_mask = 32'd0; req_bpw = v[7:0]; end
            5'd16: begin cap_freq_max = 32'd0; req_freq = v; end
            default: ;
        endcase
    endtask

    // start on a falling edge, results read on the next falling edge
    task automatic fire();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        baseline();
        start = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(done == 1'b0 && status == 1'b0 && err_map == '0, "R12 reset state", {14'd0, done, status, err_map}, 32'd0);
        start = 1'b1;              // start ignored while in reset
        @(negedge clk);
        check(done == 1'b0 && err_map == '0, "R12 start during reset", {15'd0, done, err_map}, 32'd0);
        start = 1'b0;
        rst = 1'b0;
        apply(5'd1, 32'd9);
        @(negedge clk);
        check(done == 1'b0 && status == 1'b0 && err_map == '0, "R12 idle after reset", {14'd0, done, status, err_map}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [53:0] v;
            v = VEC[i];
            apply(v[53:49], v[48:17]);
            fire();
            check(done == 1'b1, "R11 done pulse", {31'd0, done}, 32'd1);
            check(err_map == v[16:0], "R1-map vector", {15'd0, err_map}, {15'd0, v[16:0]});
            check(status == (v[16:0] != '0), "R11 status", {31'd0, status}, {31'd0, (v[16:0] != '0)});
        end

        // R11 hold: error result stays while inputs become valid without start
        apply(5'd2, 32'd9);
        fire();
        baseline();
        @(negedge clk);
        check(done == 1'b0, "R11 done one cycle", {31'd0, done}, 32'd0);
        repeat (3) @(negedge clk);
        check(err_map == 17'h00002 && status, "R11 held result", {15'd0, err_map}, 32'h2);

        // R11 hold: clean result stays while inputs become bad without start
        fire();
        apply(5'd1, 32'd200);
        repeat (2) @(negedge clk);
        check(err_map == '0 && !status, "R11 held clean", {15'd0, err_map}, 32'd0);

        // R5 cap bits cleared but features not requested: no error
        baseline();
        cap_mode = 7'h00;
        fire();
        check(err_map == '0, "R5 unrequested features", {15'd0, err_map}, 32'd0);

        // R7 hold maximum zero: zero request accepted, nonzero rejected
        baseline();
        cap_hold_max = 32'd0; req_hold_dly = 32'd0;
        fire();
        check(err_map == '0, "R7 zero request on unsupported", {15'd0, err_map}, 32'd0);
        req_hold_dly = 32'd1;
        fire();
        check(err_map == 17'h01000, "R7 nonzero on unsupported", {15'd0, err_map}, 32'h1000);

        // back-to-back starts
        apply(5'd12, 32'd3);
        start = 1'b1;
        @(negedge clk);
        apply(5'd0, 32'd0);
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1 && err_map == '0, "R11 back-to-back second", {15'd0, err_map}, 32'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule